// File: doc/BRIEF.md
# Serial Peripheral Target Port with Select Synchronization

This block is the target (slave) end of a four-wire serial peripheral link. The remote controller supplies the serial clock, and the block never generates it. Each transfer moves one byte in and one byte out, most significant bit first. The serial clock, the active-low select and the serial data input each pass through a multi-stage synchronizer into the local system clock. Clock edges are then found in that domain, so the system clock must run at least four times faster than the serial clock.

Two configuration bits set the clock idle level and which edge samples the input, which together give the four usual clocking modes. A third bit decides whether the select pin gates the port at all. A received byte is copied into a holding buffer and raises a completion flag. Software loads the outgoing byte through a write port, reads the received byte with a read strobe, and clears the sticky flags with a single clear input. The serial output is given as a data bit plus an output-enable, and the pad floats it when the enable is low. Releasing select in the middle of a byte aborts that byte: the bit count returns to zero and the output stops being driven.

Top module: `spi_tgt`

## Requirements
- R1: After the eighth sampling edge of a byte, the byte received MSB first appears on `rx_data` and `rx_done` is 1. This holds in all four clock modes.
- R2: The byte held in the transmit buffer leaves on `miso_o` MSB first. With `cfg_early`=1 its bit 7 is on the line as soon as select falls. With `cfg_early`=0, `miso_o` is 0 until the first edge leaving idle, and that edge presents bit 7.
- R3: `cfg_idle_hi` gives the serial clock level between transfers. With `cfg_early`=1 the input is sampled on the edge leaving idle and the output changes on the edge returning to idle. With `cfg_early`=0 the two edges swap roles.
- R4: `miso_oe` is 1 only while the port is active: enabled, with a valid configuration, with `sel_n_i` low (when select control is on), and with `cfg_rx_only`=0.
- R5: A select release in mid-byte makes `miso_oe` 0 within three system clocks and discards the partial byte: `rx_done` stays 0, and the next full transfer is received whole.
- R6: Clearing `cfg_en` floats the output and forces the bit count to zero, even in mid-byte.
- R7: With `cfg_rx_only`=1 the output is never driven, but reception and completion work as normal.
- R8: `cfg_early`=1 with `cfg_sel_en`=0 is an illegal setting. It sets `cfg_err`=1 and keeps the port inactive: no drive and no reception.
- R9: A `tx_wr` while a byte is partly shifted sets `tx_wcol` and leaves the byte being sent unchanged.
- R10: When a byte completes while `rx_done` is 1 and the previous byte has not been read (`rx_rd`), `rx_ovf` is set and `rx_data` keeps the old byte.
- R11: `flag_clr` clears `rx_done`, `rx_ovf` and `tx_wcol`. A `rx_rd` pulse marks the byte as read, so the next byte replaces it without overflow.
- R12: With `cfg_sel_en`=0 (and `cfg_early`=0) the select pin is ignored, and the port transfers whenever it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable; 0 aborts and idles the port |
| cfg_idle_hi | input | 1 | Serial clock idle level |
| cfg_early | input | 1 | 1: sample on the edge leaving idle and present the first bit at select fall |
| cfg_sel_en | input | 1 | 1: the select pin gates transfers |
| cfg_rx_only | input | 1 | 1: never drive the serial output |
| sclk_i | input | 1 | Serial clock from the controller |
| sel_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (0 when not driven) |
| miso_oe | output | 1 | Output enable for the serial data pad |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe: the held byte has been consumed |
| rx_data | output | DATA_W | Last received byte |
| flag_clr | input | 1 | Clears the done, overflow and collision flags |
| rx_done | output | 1 | Byte completion flag |
| rx_ovf | output | 1 | Receive overflow flag |
| tx_wcol | output | 1 | Write collision flag |
| cfg_err | output | 1 | Illegal configuration indicator |

## Verification
Every pin change takes two system clocks to pass the synchronizer and one more to act on the state. The output bit and all flags therefore change on the third rising edge after the controller moves a pin. An abort removes the output enable on the second rising edge after select rises. The bench drives its pins on falling edges and holds each serial clock phase for eight system clocks. It reads the output bit just before each sampling edge and checks the flags a full phase after the transfer ends, so every sample lands well after the three-cycle latency. The assertions cover the floating-output rules and the ordering of the collision and overflow flags cycle by cycle.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
   localparam int MIN_SYNC = 2;
   localparam int MIN_WIDTH = 2;

   typedef struct packed {
      logic lead;
      logic trail;
   } sclk_evt_t;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES < spi_tgt_pkg::MIN_SYNC) begin : g_bad_stages
      $error("spi_tgt_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_clkedge.sv
module spi_tgt_clkedge
   import spi_tgt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sclk_s,
   input  logic      idle_hi,
   output sclk_evt_t evt
);
   logic sclk_q;
   logic moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign moved     = sclk_s ^ sclk_q;
   assign evt.lead  = moved & (sclk_q == idle_hi);
   assign evt.trail = moved & (sclk_q != idle_hi);
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              early,
   input  logic              lead,
   input  logic              trail,
   input  logic              mosi_s,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] tx_buf,
   output logic              miso_q,
   output logic              busy,
   output logic              byte_done,
   output logic [DATA_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] src;
   logic              sample;
   logic              launch;
   logic              at_first;

   assign sample    = early ? lead : trail;
   assign launch    = early ? trail : lead;
   assign src       = wr_load ? wr_data : tx_buf;
   assign at_first  = (cnt == '0);
   assign busy      = run & ~at_first;
   assign byte_val  = {rx_sr[DATA_W-2:0], mosi_s};
   assign byte_done = run & sample & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         rx_sr  <= '0;
         tx_sr  <= '0;
         miso_q <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         rx_sr  <= '0;
         miso_q <= 1'b0;
      end else begin
         if (sample) begin
            rx_sr <= byte_val;
            cnt   <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
         end
         if (launch) begin
            if (at_first) begin
               miso_q <= src[DATA_W-1];
               tx_sr  <= {src[DATA_W-2:0], 1'b0};
            end else begin
               miso_q <= tx_sr[DATA_W-1];
               tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
            end
         end else if (early && at_first && (start || wr_load)) begin
            miso_q <= src[DATA_W-1];
            tx_sr  <= {src[DATA_W-2:0], 1'b0};
         end else if (start) begin
            miso_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              busy,
   input  logic              rx_rd,
   input  logic              flag_clr,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] byte_val,
   output logic [DATA_W-1:0] tx_buf,
   output logic              wr_ok,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              rx_ovf,
   output logic              tx_wcol
);
   logic unread;

   assign wr_ok = tx_wr & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf  <= '0;
         tx_wcol <= 1'b0;
      end else begin
         if (wr_ok) tx_buf <= tx_data;
         if (flag_clr) tx_wcol <= 1'b0;
         if (tx_wr && busy) tx_wcol <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_done <= 1'b0;
         rx_ovf  <= 1'b0;
         unread  <= 1'b0;
      end else begin
         if (flag_clr) begin
            rx_done <= 1'b0;
            rx_ovf  <= 1'b0;
         end
         if (rx_rd) unread <= 1'b0;
         if (byte_done) begin
            if (rx_done && unread) begin
               rx_ovf <= 1'b1;
            end else begin
               rx_data <= byte_val;
               rx_done <= 1'b1;
               unread  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_idle_hi,
   input  logic              cfg_early,
   input  logic              cfg_sel_en,
   input  logic              cfg_rx_only,
   input  logic              sclk_i,
   input  logic              sel_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   input  logic              flag_clr,
   output logic              rx_done,
   output logic              rx_ovf,
   output logic              tx_wcol,
   output logic              cfg_err
);
   localparam int PINS = 3;
   localparam logic [PINS-1:0] PIN_RST = 3'b010;

   if (DATA_W < MIN_WIDTH) begin : g_bad_width
      $error("spi_tgt: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("spi_tgt: SYNC_STAGES must be at least 2");
   end

   logic [PINS-1:0]   pins_s;
   logic              sclk_s, sel_n_s, mosi_s;
   sclk_evt_t         evt;
   logic              run, run_q, start;
   logic              miso_q, busy, byte_done, wr_ok;
   logic [DATA_W-1:0] byte_val, tx_buf;

   spi_tgt_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sclk_i, sel_n_i, mosi_i}),
      .q    (pins_s)
   );
   assign {sclk_s, sel_n_s, mosi_s} = pins_s;

   spi_tgt_clkedge i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (sclk_s),
      .idle_hi(cfg_idle_hi),
      .evt    (evt)
   );

   assign cfg_err = cfg_early & ~cfg_sel_en;
   assign run     = cfg_en & ~cfg_err & (~cfg_sel_en | ~sel_n_s);
   assign start   = run & ~run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run;
   end

   spi_tgt_shifter #(.DATA_W(DATA_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .start    (start),
      .early    (cfg_early),
      .lead     (evt.lead),
      .trail    (evt.trail),
      .mosi_s   (mosi_s),
      .wr_load  (wr_ok),
      .wr_data  (tx_data),
      .tx_buf   (tx_buf),
      .miso_q   (miso_q),
      .busy     (busy),
      .byte_done(byte_done),
      .byte_val (byte_val)
   );

   spi_tgt_regs #(.DATA_W(DATA_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_wr    (tx_wr),
      .tx_data  (tx_data),
      .busy     (busy),
      .rx_rd    (rx_rd),
      .flag_clr (flag_clr),
      .byte_done(byte_done),
      .byte_val (byte_val),
      .tx_buf   (tx_buf),
      .wr_ok    (wr_ok),
      .rx_data  (rx_data),
      .rx_done  (rx_done),
      .rx_ovf   (rx_ovf),
      .tx_wcol  (tx_wcol)
   );

   assign miso_oe = run & ~cfg_rx_only;
   assign miso_o  = miso_oe & miso_q;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              cfg_sel_en,
   input logic              cfg_rx_only,
   input logic              cfg_err,
   input logic              sel_n_i,
   input logic              miso_oe,
   input logic              tx_wr,
   input logic              tx_wcol,
   input logic              rx_ovf,
   input logic [DATA_W-1:0] rx_data
);
   // R5: select held high for three cycles leaves the pad floating
   a_r5_release_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel_en && $past(cfg_sel_en) && sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2))
      |-> !miso_oe);

   // R6: a disabled port never drives
   a_r6_off_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> !miso_oe);

   // R7: receive-only mode never drives
   a_r7_rx_only_floats: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rx_only |-> !miso_oe);

   // R8: illegal configuration keeps the port quiet
   a_r8_bad_cfg_floats: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !miso_oe);

   // R9: a collision only follows a write strobe
   a_r9_wcol_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_wcol) |-> $past(tx_wr));

   // R10: an overflow never replaces the held byte
   a_r10_ovf_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> $stable(rx_data));
endmodule

bind spi_tgt spi_tgt_chk #(.DATA_W(DATA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_en     (cfg_en),
   .cfg_sel_en (cfg_sel_en),
   .cfg_rx_only(cfg_rx_only),
   .cfg_err    (cfg_err),
   .sel_n_i    (sel_n_i),
   .miso_oe    (miso_oe),
   .tx_wr      (tx_wr),
   .tx_wcol    (tx_wcol),
   .rx_ovf     (rx_ovf),
   .rx_data    (rx_data)
);

// File: tb/test_spi_tgt.sv
module test_spi_tgt;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;
   localparam int NVEC = 8;
   // {idle_hi, early, slave byte, master byte}
   localparam logic [17:0] VECS [0:NVEC-1] = '{
      {1'b0, 1'b1, 8'hA5, 8'h3C},
      {1'b0, 1'b0, 8'h5A, 8'hC3},
      {1'b1, 1'b1, 8'h0F, 8'hF0},
      {1'b1, 1'b0, 8'h81, 8'h7E},
      {1'b0, 1'b1, 8'hFF, 8'h00},
      {1'b0, 1'b0, 8'h00, 8'hFF},
      {1'b1, 1'b1, 8'h96, 8'h69},
      {1'b1, 1'b0, 8'h01, 8'h80}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_idle_hi = 1'b0, cfg_early = 1'b1, cfg_sel_en = 1'b1, cfg_rx_only = 1'b0;
   logic sclk_i = 1'b0, sel_n_i = 1'b1, mosi_i = 1'b0;
   logic miso_o, miso_oe;
   logic tx_wr = 1'b0;
   logic [7:0] tx_data = '0;
   logic rx_rd = 1'b0, flag_clr = 1'b0;
   logic [7:0] rx_data;
   logic rx_done, rx_ovf, tx_wcol, cfg_err;

   int checks = 0;
   int fails = 0;
   logic [7:0] m_in;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_tgt i_spi_tgt (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_idle_hi(cfg_idle_hi),
      .cfg_early(cfg_early), .cfg_sel_en(cfg_sel_en), .cfg_rx_only(cfg_rx_only),
      .sclk_i(sclk_i), .sel_n_i(sel_n_i), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .tx_wr(tx_wr), .tx_data(tx_data),
      .rx_rd(rx_rd), .rx_data(rx_data), .flag_clr(flag_clr),
      .rx_done(rx_done), .rx_ovf(rx_ovf), .tx_wcol(tx_wcol), .cfg_err(cfg_err)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic idle, input logic early, input logic sel_en, input logic rxo);
      cfg_en = 1'b0;
      cfg_idle_hi = idle; cfg_early = early; cfg_sel_en = sel_en; cfg_rx_only = rxo;
      sclk_i = idle;
      cyc(6);
      cfg_en = 1'b1;
      cyc(3);
   endtask

   task automatic write_tx(input logic [7:0] d);
      tx_wr = 1'b1; tx_data = d;
      cyc(1);
      tx_wr = 1'b0;
   endtask

   task automatic clear_all();
      rx_rd = 1'b1; flag_clr = 1'b1;
      cyc(1);
      rx_rd = 1'b0; flag_clr = 1'b0;
      cyc(1);
   endtask

   task automatic spi_bits(input logic [7:0] m, input int from, input int upto);
      for (int i = from; i < upto; i++) begin
         mosi_i = m[7-i];
         cyc(H);
         if (cfg_early) m_in = {m_in[6:0], miso_o};
         sclk_i = ~cfg_idle_hi;
         cyc(H);
         if (!cfg_early) m_in = {m_in[6:0], miso_o};
         sclk_i = cfg_idle_hi;
         cyc(4);
      end
   endtask

   task automatic xfer(input logic [7:0] m);
      m_in = '0;
      sel_n_i = 1'b0;
      cyc(H);
      spi_bits(m, 0, 8);
      cyc(H);
      sel_n_i = 1'b1;
      cyc(H);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(2);
      chk("reset miso_oe", {7'd0, miso_oe}, 8'd0);
      chk("reset rx_done", {7'd0, rx_done}, 8'd0);
      chk("reset rx_ovf", {7'd0, rx_ovf}, 8'd0);
      chk("reset tx_wcol", {7'd0, tx_wcol}, 8'd0);
      chk("reset rx_data", rx_data, 8'h00);

      // table walk: all four clock modes (R1 R2 R3)
      for (int v = 0; v < NVEC; v++) begin
         set_cfg(VECS[v][17], VECS[v][16], 1'b1, 1'b0);
         write_tx(VECS[v][15:8]);
         xfer(VECS[v][7:0]);
         chk("R1 R3 rx_data", rx_data, VECS[v][7:0]);
         chk("R2 R3 shifted out", m_in, VECS[v][15:8]);
         chk("R1 rx_done", {7'd0, rx_done}, 8'd1);
         clear_all();
         chk("R11 done cleared", {7'd0, rx_done}, 8'd0);
      end

      // R4 and R2: drive only while selected, first bit at select fall
      set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
      write_tx(8'hA5);
      chk("R4 idle float", {7'd0, miso_oe}, 8'd0);
      sel_n_i = 1'b0;
      cyc(H);
      chk("R4 driven", {7'd0, miso_oe}, 8'd1);
      chk("R2 first bit early", {7'd0, miso_o}, 8'd1);
      sel_n_i = 1'b1;
      cyc(4);
      chk("R4 released", {7'd0, miso_oe}, 8'd0);

      // R5: abort mid-byte
      write_tx(8'hAA);
      m_in = '0;
      sel_n_i = 1'b0;
      cyc(H);
      spi_bits(8'hFF, 0, 3);
      sel_n_i = 1'b1;
      cyc(3);
      chk("R5 float after abort", {7'd0, miso_oe}, 8'd0);
      cyc(H);
      chk("R5 no done on abort", {7'd0, rx_done}, 8'd0);
      xfer(8'h3C);
      chk("R5 whole byte after abort", rx_data, 8'h3C);
      chk("R5 tx restarts", m_in, 8'hAA);
      clear_all();

      // R6: disable mid-byte
      m_in = '0;
      sel_n_i = 1'b0;
      cyc(H);
      spi_bits(8'hFF, 0, 3);
      cfg_en = 1'b0;
      cyc(4);
      chk("R6 disabled float", {7'd0, miso_oe}, 8'd0);
      cfg_en = 1'b1;
      cyc(4);
      m_in = '0;
      spi_bits(8'h5A, 0, 8);
      cyc(H);
      sel_n_i = 1'b1;
      cyc(H);
      chk("R6 count restarted", rx_data, 8'h5A);
      clear_all();

      // R7: receive only
      set_cfg(1'b0, 1'b1, 1'b1, 1'b1);
      sel_n_i = 1'b0;
      cyc(H);
      chk("R7 no drive", {7'd0, miso_oe}, 8'd0);
      sel_n_i = 1'b1;
      cyc(H);
      xfer(8'h81);
      chk("R7 still receives", rx_data, 8'h81);
      chk("R7 done", {7'd0, rx_done}, 8'd1);
      clear_all();

      // R9: write collision
      set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
      write_tx(8'hC3);
      m_in = '0;
      sel_n_i = 1'b0;
      cyc(H);
      spi_bits(8'h66, 0, 3);
      write_tx(8'h11);
      cyc(1);
      chk("R9 wcol set", {7'd0, tx_wcol}, 8'd1);
      spi_bits(8'h66, 3, 8);
      cyc(H);
      sel_n_i = 1'b1;
      cyc(H);
      chk("R9 byte unchanged", m_in, 8'hC3);
      chk("R9 rx ok", rx_data, 8'h66);
      clear_all();
      chk("R11 wcol cleared", {7'd0, tx_wcol}, 8'd0);

      // R10: overflow keeps old byte
      xfer(8'h12);
      xfer(8'h34);
      chk("R10 ovf set", {7'd0, rx_ovf}, 8'd1);
      chk("R10 old byte kept", rx_data, 8'h12);
      clear_all();
      chk("R11 ovf cleared", {7'd0, rx_ovf}, 8'd0);

      // R11: read strobe avoids overflow
      xfer(8'h56);
      rx_rd = 1'b1;
      cyc(1);
      rx_rd = 1'b0;
      xfer(8'h78);
      chk("R11 no ovf after read", {7'd0, rx_ovf}, 8'd0);
      chk("R11 new byte", rx_data, 8'h78);
      clear_all();

      // R8: illegal configuration
      set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
      chk("R8 cfg_err", {7'd0, cfg_err}, 8'd1);
      xfer(8'hF0);
      chk("R8 no drive", {7'd0, miso_oe}, 8'd0);
      chk("R8 no reception", {7'd0, rx_done}, 8'd0);

      // R12: select ignored, late mode
      set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R12 cfg ok", {7'd0, cfg_err}, 8'd0);
      chk("R12 driven without select", {7'd0, miso_oe}, 8'd1);
      write_tx(8'h9E);
      cyc(2);
      chk("R2 late zero before edge", {7'd0, miso_o}, 8'd0);
      m_in = '0;
      spi_bits(8'h27, 0, 8);
      cyc(H);
      chk("R12 rx without select", rx_data, 8'h27);
      chk("R12 tx without select", m_in, 8'h9E);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule